// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from eight sources (for example I/O completion, a periodic timer and hardware fault detectors) and presents one of them at a time to a processor. Each source is captured on its rising edge into a pending bit. The controller picks the most urgent unmasked pending source and raises a single interrupt line. When the processor accepts the interrupt, the controller marks that source as in service and returns a vector built from a base value and the source number.

Two servicing policies are selectable. In sequential mode nothing new is presented while any handler is in service, so requests simply wait until the running handler signals completion. In nested mode the controller keeps an in-service set that behaves as a priority stack. A more urgent request preempts the running handler. Requests of the same or lower urgency wait. Each end-of-service retires the most urgent in-service entry, and the preempted handler then continues. A global enable and a per-source mask gate what may be presented without losing any captured request.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A request is captured only on a 0-to-1 transition of its input. A source held high gives exactly one pending request, and after it is acknowledged it is not presented again until the input falls and rises once more.
- R2: Among eligible pending sources the lowest index wins (index 0 is the most urgent). The vector returned on acknowledge equals VEC_BASE plus the winning index (default base 0x40).
- R3: An acknowledge taken while the interrupt line is high clears the winner's pending bit, marks it in service and drives the vector one clock later. An acknowledge while the line is low changes nothing.
- R4: Sequential mode (mode input 0): the line stays low while any source is in service, requests keep accumulating, and the most urgent one is presented after end-of-service empties the in-service set.
- R5: Nested mode (mode input 1): a pending source is presented only when its index is lower than that of the most urgent in-service source. Sources of equal or lower urgency wait.
- R6: End-of-service clears only the most urgent in-service entry. The preempted handler remains in service, so after it the line rises only for sources more urgent than the remaining entry.
- R7: A source whose mask bit is 1 stays pending but is never presented. Clearing the mask presents it.
- R8: While the global enable is 0 the line is low and new requests still latch as pending. Raising the enable presents them.
- R9: After reset the line is low, the vector is 0, and nothing is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Request inputs, bit 0 most urgent |
| src_mask | input | NUM_SRC | Per-source mask, 1 blocks presentation |
| glb_en | input | 1 | Global enable for the interrupt line |
| nest_mode | input | 1 | 0 = sequential servicing, 1 = nested preemption |
| cpu_ack | input | 1 | Processor accepts the presented interrupt |
| cpu_eos | input | 1 | Processor signals end of the current handler |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | VEC_W | Vector of the last accepted source |

## Verification
A corrupted pending or in-service bit shows up at the ports within one clock. The line either rises when no eligible request exists, or stays low when one does, and the next acknowledge returns a vector for the wrong source. A lost in-service entry makes a nested sequence present a lower-urgency source too early after end-of-service. A stuck entry keeps the line low in sequential mode after the handler has finished. The sweeps walk every source alone and every ordered pair of sources through both modes, so each such slip changes a line level or a vector that the bench has predicted.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic {
    SVC_SEQUENTIAL = 1'b0,
    SVC_NESTED     = 1'b1
  } svc_mode_e;
endpackage

// File: rtl/nic_prio_enc.sv
module nic_prio_enc #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_req,
  input  logic [N-1:0] clr_oh,
  output logic [N-1:0] pending_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] req_q;

  assign rise_o = src_req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      pending_o <= '0;
    end else begin
      req_q     <= src_req;
      pending_o <= (pending_o & ~clr_oh) | rise_o;
    end
  end

  AST_HELD_NO_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_oh != '0 && (rise_o & clr_oh) == '0) |=> ((pending_o & $past(clr_oh)) == '0)) else $error("held level relatched"); // R1
endmodule

// File: rtl/nic_svc_stack.sv
module nic_svc_stack #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_oh,
  input  logic             eos,
  output logic [N-1:0]     isr_o,
  output logic             top_found_o,
  output logic [IDX_W-1:0] top_idx_o
);
  function automatic logic [N-1:0] drop_lowest(input logic [N-1:0] v);
    return v & (v - N'(1));
  endfunction

  logic [N-1:0] isr_next;

  assign isr_next = (eos ? drop_lowest(isr_o) : isr_o) | set_oh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_o <= '0;
    else        isr_o <= isr_next;
  end

  nic_prio_enc #(.N(N)) u_top_enc (
    .vec_i   (isr_o),
    .found_o (top_found_o),
    .idx_o   (top_idx_o)
  );

  AST_EOS_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && isr_o != '0 && set_oh == '0) |=> ($countones(isr_o) == $past($countones(isr_o)) - 1)) else $error("eos did not retire one entry"); // R6
  AST_EOS_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && set_oh == '0) |=> ((isr_o & ~$past(isr_o)) == '0)) else $error("eos created an entry"); // R6
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int                 NUM_SRC  = 8,
  parameter int                 VEC_W    = 8,
  parameter logic [VEC_W-1:0]   VEC_BASE = 8'h40,
  localparam int                IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_mask,
  input  logic               glb_en,
  input  logic               nest_mode,
  input  logic               cpu_ack,
  input  logic               cpu_eos,
  output logic               irq_out,
  output logic [VEC_W-1:0]   vec_out
);
  import nic_pkg::*;

  function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
    return VEC_BASE + VEC_W'(idx);
  endfunction

  function automatic logic may_present(input svc_mode_e mode, input logic busy,
                                       input logic [IDX_W-1:0] cand,
                                       input logic [IDX_W-1:0] top);
    if (!busy) return 1'b1;
    if (mode == SVC_NESTED) return cand < top;
    return 1'b0;
  endfunction

  svc_mode_e            mode;
  logic [NUM_SRC-1:0]   pending;
  logic [NUM_SRC-1:0]   rise;
  logic [NUM_SRC-1:0]   eligible;
  logic [NUM_SRC-1:0]   isr;
  logic [NUM_SRC-1:0]   ack_oh;
  logic                 win_found;
  logic [IDX_W-1:0]     win_idx;
  logic                 svc_busy;
  logic [IDX_W-1:0]     svc_top;
  logic                 gate_open;
  logic                 ack_fire;

  assign mode      = svc_mode_e'(nest_mode);
  assign eligible  = pending & ~src_mask;
  assign gate_open = may_present(mode, svc_busy, win_idx, svc_top);
  assign irq_out   = glb_en & win_found & gate_open;
  assign ack_fire  = cpu_ack & irq_out;
  assign ack_oh    = ack_fire ? (NUM_SRC'(1) << win_idx) : '0;

  nic_req_latch #(.N(NUM_SRC)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .clr_oh    (ack_oh),
    .pending_o (pending),
    .rise_o    (rise)
  );

  nic_prio_enc #(.N(NUM_SRC)) u_win_enc (
    .vec_i   (eligible),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  nic_svc_stack #(.N(NUM_SRC)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_oh      (ack_oh),
    .eos         (cpu_eos),
    .isr_o       (isr),
    .top_found_o (svc_busy),
    .top_idx_o   (svc_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vec_out <= '0;
    else if (ack_fire) vec_out <= vector_of(win_idx);
  end

  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (vec_out == VEC_BASE + VEC_W'($past(win_idx)))) else $error("vector mismatch"); // R2
  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !cpu_eos) |=> ($countones(isr) == $past($countones(isr)) + 1)) else $error("ack did not enter service"); // R3
  AST_IGNORED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !irq_out && !cpu_eos) |=> $stable(vec_out) && $stable(isr)) else $error("ack while idle had effect"); // R3
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SVC_SEQUENTIAL && ack_fire && $stable(nest_mode)) |=> !irq_out) else $error("sequential mode presented while busy"); // R4
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !src_mask[win_idx]) else $error("masked source presented"); // R7
  AST_GLB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !ack_fire) else $error("ack accepted while disabled"); // R8
  AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && svc_busy) |-> (mode == SVC_NESTED && win_idx < svc_top)) else $error("preemption order broken"); // R5
endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  localparam int N = 8;
  localparam logic [7:0] BASE = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_req = '0;
  logic [N-1:0] src_mask = '0;
  logic glb_en = 1'b1;
  logic nest_mode = 1'b0;
  logic cpu_ack = 1'b0;
  logic cpu_eos = 1'b0;
  logic irq_out;
  logic [7:0] vec_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_mask(src_mask),
    .glb_en(glb_en), .nest_mode(nest_mode), .cpu_ack(cpu_ack), .cpu_eos(cpu_eos),
    .irq_out(irq_out), .vec_out(vec_out)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic raise(input logic [N-1:0] bits);
    src_req = src_req | bits; cyc();
    src_req = src_req & ~bits; cyc();
  endtask

  task automatic ack();
    cpu_ack = 1'b1; cyc(); cpu_ack = 1'b0;
  endtask

  task automatic eos();
    cpu_eos = 1'b1; cyc(); cpu_eos = 1'b0; cyc();
  endtask

  initial begin
    repeat (3) cyc();
    chk("R9 irq", int'(irq_out), 0);
    chk("R9 vec", int'(vec_out), 0);
    rst_n = 1'b1; cyc();
    chk("R9 idle irq", int'(irq_out), 0);

    // R3: acknowledge while idle is ignored; a later request is still presented
    ack(); cyc();
    chk("R3 idle ack vec", int'(vec_out), 0);
    raise(8'h20);
    chk("R3 after idle ack irq", int'(irq_out), 1);
    ack();
    chk("R3 vec", int'(vec_out), int'(BASE) + 5);
    chk("R3 irq drops", int'(irq_out), 0);
    eos();

    // R2 single-source sweep in both modes
    for (int m = 0; m < 2; m++) begin
      nest_mode = m[0];
      for (int i = 0; i < N; i++) begin
        raise(N'(1) << i);
        chk("R2 single irq", int'(irq_out), 1);
        ack();
        chk("R2 single vec", int'(vec_out), int'(BASE) + i);
        chk("R3 cleared", int'(irq_out), 0);
        eos();
        chk("R6 empty after eos", int'(irq_out), 0);
      end
    end

    // R4 sequential pairs
    nest_mode = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i == j) continue;
        raise((N'(1) << i) | (N'(1) << j));
        ack();
        chk("R2 pair winner", int'(vec_out), int'(BASE) + ((i < j) ? i : j));
        chk("R4 held while busy", int'(irq_out), 0);
        eos();
        chk("R4 presented after eos", int'(irq_out), 1);
        ack();
        chk("R4 second vec", int'(vec_out), int'(BASE) + ((i < j) ? j : i));
        eos();
      end
    end

    // R5/R6 nested pairs: j in service, i arrives
    nest_mode = 1'b1;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i == j) continue;
        raise(N'(1) << j); ack();
        raise(N'(1) << i);
        chk("R5 preempt decision", int'(irq_out), (i < j) ? 1 : 0);
        if (i < j) begin
          ack();
          chk("R5 preempt vec", int'(vec_out), int'(BASE) + i);
          eos();
          chk("R6 lower resumes, nothing shown", int'(irq_out), 0);
          eos();
        end else begin
          eos();
          chk("R6 waiter shown after eos", int'(irq_out), 1);
          ack();
          chk("R6 waiter vec", int'(vec_out), int'(BASE) + i);
          eos();
        end
      end
    end

    // R6 three-deep: 6 in service, 2 preempts, then 4 arrives: held until 2 retires
    raise(8'h40); ack(); raise(8'h04); ack(); raise(8'h10);
    chk("R6 mid held under 2", int'(irq_out), 0);
    eos();
    chk("R6 mid shown above 6", int'(irq_out), 1);
    ack();
    chk("R6 mid vec", int'(vec_out), int'(BASE) + 4);
    eos(); eos();
    chk("R6 stack empty", int'(irq_out), 0);

    // R7 mask sweep
    for (int i = 0; i < N; i++) begin
      src_mask = N'(1) << i;
      raise(N'(1) << i);
      chk("R7 masked hidden", int'(irq_out), 0);
      src_mask = '0; cyc();
      chk("R7 unmasked shown", int'(irq_out), 1);
      ack();
      chk("R7 vec", int'(vec_out), int'(BASE) + i);
      eos();
    end

    // R8 global disable
    glb_en = 1'b0;
    raise(8'h08); raise(8'h02);
    chk("R8 line low", int'(irq_out), 0);
    ack();
    chk("R8 ack ignored", int'(vec_out), int'(BASE) + 7);
    glb_en = 1'b1; cyc();
    chk("R8 shown on enable", int'(irq_out), 1);
    ack();
    chk("R8 first vec", int'(vec_out), int'(BASE) + 1);
    eos();
    ack();
    chk("R8 accumulated vec", int'(vec_out), int'(BASE) + 3);
    eos();

    // R1 held level
    src_req = 8'h01; cyc();
    ack();
    chk("R1 first vec", int'(vec_out), int'(BASE));
    eos(); cyc(); cyc();
    chk("R1 no relatch while high", int'(irq_out), 0);
    src_req = '0; cyc();
    src_req = 8'h01; cyc();
    chk("R1 new edge latched", int'(irq_out), 1);
    src_req = '0; ack(); eos();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule